// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block produces the source and destination addresses for one DMA channel and moves them forward one transfer at a time. A seven-bit control word chooses how each address moves after a transfer: it stays put, counts up or counts down. It also selects the transfer size and whether the source is read indirectly. The step follows the transfer size: one, two or four bytes. In indirect mode the source register holds a pointer to the location where the real data address is kept. That pointer moves by four bytes, or stays put, whatever the transfer size.

Software writes the control word, then loads the starting addresses with a load strobe. The channel engine pulses `xfer_done` once for each completed transfer. A prohibited value in any control field sets `config_error`. While it is set, transfers do not move the addresses. Loads are still accepted. A later write of a valid control word clears the flag.

The configuration checker is a two-state machine. In `ST_VALID`, transfers advance the addresses. In `ST_FAULT`, they are frozen. The transition `T_BADCFG` goes from `ST_VALID` to `ST_FAULT` on a control write that holds any prohibited field. The transition `T_GOODCFG` goes from `ST_FAULT` back to `ST_VALID` on a fully valid control write. Any other cycle keeps the current state, and this includes a bad write while already in `ST_FAULT`.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset both addresses read 0, `config_error` is 0, `size_bytes` is 1, both modes are fixed, and the source is direct.
- R2: The control word is captured on `ctrl_we`. Its layout is: bits [1:0] size (00 byte, 01 word, 10 longword, 11 prohibited); bits [3:2] destination mode and bits [5:4] source mode (00 fixed, 01 increment, 10 decrement, 11 prohibited); bit 6 indirect source. The new word governs transfers from the following cycle on.
- R3: `load` writes `load_src` and `load_dst` into the address registers, with the values visible one cycle later. A coincident `xfer_done` is ignored in that cycle.
- R4: On `xfer_done`, the source address moves by +size or −size bytes in increment or decrement mode, and is unchanged in fixed mode.
- R5: On `xfer_done`, the destination address moves the same way under its own mode field, independently of the source.
- R6: Address arithmetic wraps modulo 2^32.
- R7: With bit 6 set, the source steps by +4, −4 or 0 for any size, and the destination keeps its size-based step.
- R8: After a control write with any field at 11, `config_error` is 1 and `xfer_done` leaves both addresses unchanged, while `load` still works. A later valid write clears `config_error`.
- R9: `size_bytes` is 1, 2 or 4 for byte, word or longword, and 0 while the size field holds 11.
- R10: Without `load` or `xfer_done`, both addresses hold their values.
- R11: An `xfer_done` in the same cycle as `ctrl_we` steps by the control word that was in effect before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 7 | Control word value |
| load | input | 1 | Load strobe for both initial addresses |
| load_src | input | 32 | Initial source address (or pointer) |
| load_dst | input | 32 | Initial destination address |
| xfer_done | input | 1 | Single-cycle transfer-complete strobe |
| src_addr | output | 32 | Current source address or pointer |
| dst_addr | output | 32 | Current destination address |
| size_bytes | output | 3 | Bytes per transfer: 1, 2, 4, or 0 if prohibited |
| config_error | output | 1 | Control word holds a prohibited field |

## Verification
Two pairs of functions can fall in the same cycle, and the bench provokes each one directly.

The first pair is an address load and a transfer step. The bench raises `load` and `xfer_done` on the same edge, in both a valid and a faulted configuration. It then judges that the loaded values appear unchanged by any step.

The second pair is a control write and a transfer step. The bench pulses `ctrl_we` with a new direction and size together with `xfer_done`. It expects the step of the old word on that edge, and the step of the new word only on the next transfer.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int CTRL_W = 7;

    typedef enum logic [1:0] {
        AM_FIXED = 2'b00,
        AM_INC   = 2'b01,
        AM_DEC   = 2'b10,
        AM_BAD   = 2'b11
    } addr_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_BAD  = 2'b11
    } xfer_size_e;

    // bit 6 indirect, [5:4] source mode, [3:2] destination mode, [1:0] size
    typedef struct packed {
        logic       indirect;
        addr_mode_e src_mode;
        addr_mode_e dst_mode;
        xfer_size_e size;
    } seq_ctrl_t;

    typedef enum logic {
        ST_VALID = 1'b0,
        ST_FAULT = 1'b1
    } cfg_state_e;

    function automatic logic ctrl_bad(input seq_ctrl_t c);
        return (c.src_mode == AM_BAD) || (c.dst_mode == AM_BAD) || (c.size == SZ_BAD);
    endfunction

    function automatic logic [2:0] size_to_bytes(input xfer_size_e s);
        logic [2:0] b;
        unique case (s)
            SZ_BYTE: b = 3'd1;
            SZ_WORD: b = 3'd2;
            SZ_LONG: b = 3'd4;
            default: b = 3'd0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dma_cfg_fsm.sv
module dma_cfg_fsm
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output seq_ctrl_t         ctrl_q,
    output logic              fault
);

    cfg_state_e state_q, state_d;
    seq_ctrl_t  wr_word;

    assign wr_word = seq_ctrl_t'(ctrl_wdata);

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{indirect: 1'b0, src_mode: AM_FIXED, dst_mode: AM_FIXED, size: SZ_BYTE};
        end else if (ctrl_we) begin
            ctrl_q <= wr_word;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_VALID;
        else        state_q <= state_d;
    end

    // transitions: T_BADCFG, T_GOODCFG
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_VALID: if (ctrl_we && ctrl_bad(wr_word))  state_d = ST_FAULT;
            ST_FAULT: if (ctrl_we && !ctrl_bad(wr_word)) state_d = ST_VALID;
            default:  state_d = ST_VALID;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_FAULT: fault = 1'b1;
            default:  fault = 1'b0;
        endcase
    end

    AST_BADCFG_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && ctrl_bad(seq_ctrl_t'(ctrl_wdata)) |=> fault); // R8
    AST_GOODCFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && !ctrl_bad(seq_ctrl_t'(ctrl_wdata)) |=> !fault); // R8

endmodule

// File: rtl/dma_step_calc.sv
module dma_step_calc
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  addr_mode_e        mode,
    input  xfer_size_e        size,
    input  logic              ptr_mode,
    output logic [ADDR_W-1:0] step
);

    localparam logic [2:0] PTR_STEP = 3'd4;

    logic [2:0]        mag;
    logic [ADDR_W-1:0] mag_ext;

    always_comb begin
        mag     = ptr_mode ? PTR_STEP : size_to_bytes(size);
        mag_ext = ADDR_W'(mag);
        unique case (mode)
            AM_INC:  step = mag_ext;
            AM_DEC:  step = '0 - mag_ext;
            default: step = '0;
        endcase
    end

endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    input  logic [ADDR_W-1:0] step,
    output logic [ADDR_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (adv)  q <= q + step;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(load_val)); // R3

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_src,
    input  logic [ADDR_W-1:0] load_dst,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [2:0]        size_bytes,
    output logic              config_error
);

    localparam int NCH = 2;  // 0 = source, 1 = destination

    seq_ctrl_t   ctrl_q;
    logic        fault;
    logic        adv;
    addr_mode_e  mode_a  [NCH];
    logic        ptr_a   [NCH];
    logic [ADDR_W-1:0] ld_a   [NCH];
    logic [ADDR_W-1:0] step_a [NCH];
    logic [ADDR_W-1:0] q_a    [NCH];

    dma_cfg_fsm u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_q     (ctrl_q),
        .fault      (fault)
    );

    assign adv = xfer_done && !fault;

    assign mode_a[0] = ctrl_q.src_mode;
    assign mode_a[1] = ctrl_q.dst_mode;
    assign ptr_a[0]  = ctrl_q.indirect;
    assign ptr_a[1]  = 1'b0;
    assign ld_a[0]   = load_src;
    assign ld_a[1]   = load_dst;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dma_step_calc #(.ADDR_W(ADDR_W)) u_step (
            .mode     (mode_a[i]),
            .size     (ctrl_q.size),
            .ptr_mode (ptr_a[i]),
            .step     (step_a[i])
        );
        dma_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .load_val (ld_a[i]),
            .adv      (adv),
            .step     (step_a[i]),
            .q        (q_a[i])
        );
    end

    assign src_addr     = q_a[0];
    assign dst_addr     = q_a[1];
    assign size_bytes   = size_to_bytes(ctrl_q.size);
    assign config_error = fault;

    AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        config_error && xfer_done && !load |=> $stable(src_addr) && $stable(dst_addr)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !xfer_done |=> $stable(src_addr) && $stable(dst_addr)); // R10
    AST_DST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !config_error && xfer_done && !load && ctrl_q.dst_mode == AM_INC
        |=> dst_addr == $past(dst_addr) + ADDR_W'($past(size_bytes))); // R5
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !config_error && xfer_done && !load && ctrl_q.indirect && ctrl_q.src_mode == AM_DEC
        |=> src_addr == $past(src_addr) - ADDR_W'(4)); // R7
    AST_SIZE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(size_bytes)); // R9

endmodule

// File: tb/sim_dma_addr_seq.sv
module sim_dma_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [6:0]  ctrl_wdata = '0;
    logic        load = 1'b0;
    logic [31:0] load_src = '0;
    logic [31:0] load_dst = '0;
    logic        xfer_done = 1'b0;
    logic [31:0] src_addr, dst_addr;
    logic [2:0]  size_bytes;
    logic        config_error;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    dma_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .load(load), .load_src(load_src), .load_dst(load_dst), .xfer_done(xfer_done),
        .src_addr(src_addr), .dst_addr(dst_addr), .size_bytes(size_bytes),
        .config_error(config_error)
    );

    // ctrl(7) | s0 | d0 | s1 | d1
    localparam int NV = 9;
    localparam logic [134:0] VECS [NV] = '{
        {7'h14, 32'h0000_1000, 32'h0000_2000, 32'h0000_1001, 32'h0000_2001},
        {7'h25, 32'h0000_1000, 32'h0000_2000, 32'h0000_0FFE, 32'h0000_2002},
        {7'h1A, 32'h0000_1000, 32'h0000_2000, 32'h0000_1004, 32'h0000_1FFC},
        {7'h02, 32'h0000_1000, 32'h0000_2000, 32'h0000_1000, 32'h0000_2000},
        {7'h1A, 32'hFFFF_FFFE, 32'h0000_0001, 32'h0000_0002, 32'hFFFF_FFFD},
        {7'h54, 32'h0000_4000, 32'h0000_5000, 32'h0000_4004, 32'h0000_5001},
        {7'h61, 32'h0000_4000, 32'h0000_5000, 32'h0000_3FFC, 32'h0000_5000},
        {7'h4A, 32'h0000_4000, 32'h0000_5000, 32'h0000_4000, 32'h0000_4FFC},
        {7'h20, 32'h0000_0000, 32'h0000_0007, 32'hFFFF_FFFF, 32'h0000_0007}
    };

    function automatic logic [2:0] exp_bytes(input logic [1:0] sz);
        return (sz == 2'b00) ? 3'd1 : (sz == 2'b01) ? 3'd2 : (sz == 2'b10) ? 3'd4 : 3'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // inputs change 1 ns after a rising edge; outputs sampled 1 ns after the next
    task automatic tick();
        @(posedge clk);
        #1;
        ctrl_we = 1'b0;
        load = 1'b0;
        xfer_done = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [6:0] w);
        ctrl_we = 1'b1; ctrl_wdata = w; tick();
    endtask

    task automatic do_load(input logic [31:0] s, input logic [31:0] d);
        load = 1'b1; load_src = s; load_dst = d; tick();
    endtask

    task automatic do_xfer();
        xfer_done = 1'b1; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 src", src_addr, 32'h0);
        chk("R1 dst", dst_addr, 32'h0);
        chk("R1 err", 32'(config_error), 32'h0);
        chk("R1 size", 32'(size_bytes), 32'h1);
        do_xfer();
        chk("R1 fixed after xfer src", src_addr, 32'h0);
        chk("R1 fixed after xfer dst", dst_addr, 32'h0);

        // table: R2 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            wr_ctrl(VECS[i][134:128]);
            do_load(VECS[i][127:96], VECS[i][95:64]);
            chk("R3 load src", src_addr, VECS[i][127:96]);
            chk("R3 load dst", dst_addr, VECS[i][95:64]);
            chk("R9 size", 32'(size_bytes), 32'(exp_bytes(VECS[i][129:128])));
            do_xfer();
            chk("R4/R6/R7 src step", src_addr, VECS[i][63:32]);
            chk("R5/R6 dst step", dst_addr, VECS[i][31:0]);
            chk("R2 err clear", 32'(config_error), 32'h0);
        end

        // R10 idle hold
        repeat (5) tick();
        chk("R10 src hold", src_addr, 32'hFFFF_FFFF);
        chk("R10 dst hold", dst_addr, 32'h0000_0007);

        // R3 load beats coincident transfer
        wr_ctrl(7'h14);
        load = 1'b1; load_src = 32'h100; load_dst = 32'h200; xfer_done = 1'b1; tick();
        chk("R3 priority src", src_addr, 32'h100);
        chk("R3 priority dst", dst_addr, 32'h200);

        // R11 control write with coincident transfer uses old word
        ctrl_we = 1'b1; ctrl_wdata = 7'h2A; xfer_done = 1'b1; tick();
        chk("R11 old word src", src_addr, 32'h101);
        chk("R11 old word dst", dst_addr, 32'h201);
        do_xfer();
        chk("R11 new word src", src_addr, 32'hFD);
        chk("R11 new word dst", dst_addr, 32'h1FD);

        // R8 prohibited settings
        wr_ctrl(7'h34);
        chk("R8 src mode bad err", 32'(config_error), 32'h1);
        do_xfer();
        chk("R8 frozen src", src_addr, 32'hFD);
        chk("R8 frozen dst", dst_addr, 32'h1FD);
        do_load(32'hAAAA, 32'hBBBB);
        chk("R8 load in fault src", src_addr, 32'hAAAA);
        chk("R8 load in fault dst", dst_addr, 32'hBBBB);
        load = 1'b1; load_src = 32'h11; load_dst = 32'h22; xfer_done = 1'b1; tick();
        chk("R3 priority in fault src", src_addr, 32'h11);
        wr_ctrl(7'h0C);
        chk("R8 dst mode bad err", 32'(config_error), 32'h1);
        wr_ctrl(7'h03);
        chk("R8 size bad err", 32'(config_error), 32'h1);
        chk("R9 size bad", 32'(size_bytes), 32'h0);
        do_xfer();
        chk("R8 frozen dst again", dst_addr, 32'h22);
        wr_ctrl(7'h14);
        chk("R8 err cleared", 32'(config_error), 32'h0);
        do_xfer();
        chk("R8 resume src", src_addr, 32'h12);
        chk("R8 resume dst", dst_addr, 32'h23);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule